// File: doc/BRIEF.md
# Prescaled One-Shot Interval Timer

This block measures out one interval and then stops. Software programs a configuration word that holds a 4-bit prescaler code and a 12-bit terminal count. It then writes the start bit in the control word. The prescaler divides the clock by two raised to the code. The main counter advances once per prescaler tick. When the counter reaches the terminal count, hardware sets a read-only completion flag and drops the start bit by itself.

A halt request output can be enabled in the control word. When it is enabled, the output stays high for exactly the cycles in which the timer runs, so that a processor core can be stalled for the programmed time. The configuration is copied into working registers at each start. A configuration write therefore affects only the next interval.

Both words are reached over a single-cycle synchronous bus with a one-bit address. The read data is combinational from the address.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, both words read as 0 and `halt_req` is low.
- R2: Address 0 selects the control word and address 1 selects the configuration word. The control word holds the completion flag in bit 15, the run bit in bit 14 and the halt enable in bit 0. Bits 13 to 1 always read 0. The configuration word holds the prescaler code in bits 15:12 and the terminal count in bits 11:0, and it reads back exactly as written.
- R3: A control write with bit 14 set clears the completion flag and sets the run bit from the next cycle on.
- R4: After a start, the run bit stays high for exactly (count+1)·2^code cycles. After that, the flag reads 1 and the run bit reads 0.
- R5: A terminal count of 0 with code 0 completes one cycle after the start.
- R6: `halt_req` is high exactly in the cycles where the run bit reads 1 and the halt enable reads 1. It never goes high while the halt enable is 0.
- R7: A start written while the timer is running restarts the full interval from zero.
- R8: A control write with bit 14 clear stops the timer at once and leaves the completion flag unchanged. This also holds in the cycle where the interval would have ended.
- R9: A configuration write during a running interval does not change the length of that interval.
- R10: Bit 15 of a control write is ignored. Only the hardware sets the flag, and only a start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Word select: 0 control, 1 configuration |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word |
| halt_req | output | 1 | Processor halt request while running |

## Verification
The assertions assume that each write lasts exactly one cycle and touches one word, so a start and a configuration write never happen in the same cycle. The stimulus keeps within this because every access goes through a task that raises the strobe for a single cycle. The assertions also assume that the prescaler code in the working copy stays fixed while the timer runs; the register logic guarantees this. The stimulus uses prescaler codes no larger than 3, so that every interval ends within a few thousand cycles. Some writes are placed inside running intervals, including one on the cycle where an interval would end, to exercise the write-wins priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned CODE_W = 4;
  parameter int unsigned CNT_W  = 12;

  // Control word bit positions (software-visible)
  parameter int unsigned BIT_FLAG = 15;
  parameter int unsigned BIT_RUN  = 14;
  parameter int unsigned BIT_HALT = 0;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_CFG = 1'b1} word_sel_e;

  // Last prescaler phase before a tick: 2^code - 1
  function automatic int unsigned phase_limit(int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

  // Total running cycles of one interval
  function automatic longint unsigned interval_len(int unsigned code, int unsigned cnt);
    return (longint'(cnt) + 1) << code;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CODE_W = tmr_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned PH_W = (1 << CODE_W) - 1;

  logic [PH_W-1:0] phase;
  logic            at_limit;

  assign at_limit = (phase == PH_W'(tmr_pkg::phase_limit(32'(code))));
  assign tick     = run && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n || start || !run) phase <= '0;
    else if (at_limit)           phase <= '0;
    else                         phase <= phase + 1'b1;
  end

  // R4: the phase never runs past the limit of the latched code
  a_r4_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run && !start && !tick |=> phase != '0 || !run);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = tmr_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || start)           cnt <= '0;
    else if (run && tick && !expire) cnt <= cnt + 1'b1;
  end

  // R4: the count moves only on prescaler ticks
  a_r4_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick && !start |=> $stable(cnt));
  // R4: the count never passes the terminal value
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    run && !start |-> cnt <= limit);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int unsigned DATA_W = tmr_pkg::DATA_W,
  parameter int unsigned CODE_W = tmr_pkg::CODE_W,
  parameter int unsigned CNT_W  = tmr_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire,
  output logic              start,
  output logic              run,
  output logic              halt_en,
  output logic [CODE_W-1:0] act_code,
  output logic [CNT_W-1:0]  act_limit
);
  import tmr_pkg::*;

  logic              flag;
  logic [DATA_W-1:0] cfg;
  logic              ctrl_wr, abort;
  logic [DATA_W-1:0] ctrl_view;
  logic              unused_wbits;

  assign ctrl_wr      = bus_wr && (bus_addr == SEL_CFG) == 1'b0;
  assign start        = ctrl_wr && bus_wdata[BIT_RUN];
  assign abort        = ctrl_wr && !bus_wdata[BIT_RUN];
  assign unused_wbits = ^{bus_wdata[BIT_RUN-1:BIT_HALT+1], bus_wdata[BIT_FLAG]};

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[BIT_FLAG] = flag;
    ctrl_view[BIT_RUN]  = run;
    ctrl_view[BIT_HALT] = halt_en;
  end
  assign bus_rdata = (bus_addr == SEL_CFG) ? cfg : ctrl_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0; run <= 1'b0; halt_en <= 1'b0; cfg <= '0;
      act_code <= '0; act_limit <= '0;
    end else begin
      if (bus_wr && bus_addr == SEL_CFG) cfg <= bus_wdata;
      if (ctrl_wr) halt_en <= bus_wdata[BIT_HALT];
      if (start) begin
        run       <= 1'b1;
        flag      <= 1'b0;
        act_code  <= cfg[DATA_W-1 -: CODE_W];
        act_limit <= cfg[CNT_W-1:0];
      end else if (abort) begin
        run <= 1'b0;
      end else if (expire && run) begin
        run  <= 1'b0;
        flag <= 1'b1;
      end
    end
  end

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run && !flag);
  a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire && run && !ctrl_wr |=> flag && !run);
  a_r8_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !run && $stable(flag));
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run && !start |=> $stable(act_limit) && $stable(act_code));
  a_r10_flag_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !(expire && run) |=> $stable(flag));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned DATA_W = tmr_pkg::DATA_W,
  parameter int unsigned CODE_W = tmr_pkg::CODE_W,
  parameter int unsigned CNT_W  = tmr_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              halt_req
);
  logic              start, run, halt_en, tick, expire;
  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  act_limit;

  tmr_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
    .start(start), .run(run), .halt_en(halt_en),
    .act_code(act_code), .act_limit(act_limit));

  tmr_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .code(act_code), .tick(tick));

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run),
    .tick(tick), .limit(act_limit), .expire(expire));

  assign halt_req = run && halt_en;

  // R6: halt is released in the cycle after the interval ends
  a_r6_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !bus_wr |=> !halt_req);
endmodule

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        halt_req;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  bit          m_run, m_flag, m_halt;
  logic [15:0] m_cfg;
  longint      m_left;

  always #10 clk = ~clk;

  oneshot_timer uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt_req(halt_req));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_flag = 0; m_halt = 0; m_cfg = '0; m_left = 0;
    end else if (bus_wr && bus_addr) begin
      m_cfg = bus_wdata;
      if (m_run) begin m_left--; if (m_left == 0) begin m_run = 0; m_flag = 1; end end
    end else if (bus_wr) begin
      m_halt = bus_wdata[0];
      if (bus_wdata[14]) begin
        m_run = 1; m_flag = 0;
        m_left = (longint'(m_cfg[11:0]) + 1) * (longint'(1) << m_cfg[15:12]);
      end else m_run = 0;
    end else if (m_run) begin
      m_left--;
      if (m_left == 0) begin m_run = 0; m_flag = 1; end
    end
  end

  always @(posedge clk) begin
    logic [15:0] exp_rd;
    #5;
    exp_rd = bus_addr ? m_cfg : {m_flag, m_run, 13'b0, m_halt};
    checks++;
    if (bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, bus_addr, bus_rdata, exp_rd);
    end
    checks++;
    if (halt_req !== (m_run && m_halt)) begin
      errors++;
      $display("FAIL R6 halt_req (%s) actual=%b expected=%b", tag, halt_req, m_run && m_halt);
    end
  end

  task automatic wr(input bit a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0; bus_wdata = '0;
  endtask
  task automatic peek_cfg();
    @(negedge clk); bus_addr = 1;
    @(negedge clk); bus_addr = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    tag = "R1"; peek_cfg();
    tag = "R2"; wr(1, 16'h0000); peek_cfg();
    wr(1, 16'hA5C3); peek_cfg();
    tag = "R5"; wr(1, 16'h0000); wr(0, 16'h4001); idle(4);
    tag = "R4"; wr(1, 16'h2005); wr(0, 16'h4000); idle(30);
    tag = "R6"; wr(1, 16'h1003); wr(0, 16'h4001); idle(12);
    tag = "R9"; wr(1, 16'h3002); wr(0, 16'h4001); idle(5);
    wr(1, 16'h0001); peek_cfg(); idle(25);
    tag = "R7"; wr(1, 16'h1006); wr(0, 16'h4001); idle(6);
    wr(0, 16'h4001); idle(20);
    tag = "R8"; wr(1, 16'h000A); wr(0, 16'h4000); idle(3);
    wr(0, 16'h0001); idle(15);
    tag = "R8"; wr(1, 16'h0002); wr(0, 16'h4000); idle(1); wr(0, 16'h0000); idle(4);
    tag = "R10"; wr(0, 16'hBFFE); idle(3); wr(0, 16'h8000); idle(3);
    wr(1, 16'h0000); wr(0, 16'h4000); idle(3); wr(0, 16'h8000); idle(3);
    tag = "R3"; wr(1, 16'h0FFF); wr(0, 16'h4001); idle(4200);
    tag = "R1"; @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (%s)", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule